// File: doc/BRIEF.md
# Acquisition Sample Clock Timing Engine

This block times the sample events of a data acquisition. It runs on a single timebase clock and produces sample events in one of two ways. In internal mode a down-counter is armed by a start trigger, waits a programmable number of ticks, and then fires once every sample period. In external mode it turns rising edges of an asynchronous sample clock input into sample events. A sample event only becomes a sample strobe while an acquisition is active and the pause input is low. In finite mode the acquisition ends by itself after a programmed number of samples that were not masked. In either mode a software stop request also ends it.

Configuration sits in a small register set that is written through a load strobe. The registers are the sample period, the start delay, the sample count, finite mode, external source select and output style. The per-sample output is active high. It gives either a one-tick pulse per sample or a level that covers the sample interval.

Top module: `acq_sample_timer`

## Requirements
- R1: After reset, every output is low. The configuration resets to period 2, start delay 2, sample count 1, continuous mode, internal source and pulse output.
- R2: With the internal source, a start trigger sampled at edge E0 raises `acq_active` after E0. The first `sample_strobe` is high in the cycle after edge E0+D, where D is the start delay, and a delay of 0 acts as 1.
- R3: Internal sample events repeat every P ticks after the first one. A period below 2 acts as 2.
- R4: If `pause_trig` is high at the edge where a sample event falls, that event gives no strobe and is not counted. The internal counter keeps its timing while paused.
- R5: While no acquisition is active, there is no strobe and no output activity, even when the external clock toggles.
- R6: In finite mode, the acquisition ends at the edge of the N-th unmasked sample, where a count of 0 acts as 1. At that edge `acq_done` pulses high for one cycle together with the last strobe, and `acq_active` falls.
- R7: `sw_stop` during an acquisition ends it at that edge. `acq_done` pulses for one cycle and no strobe is issued at that edge. While idle, `sw_stop` has no effect.
- R8: A start trigger that arrives during an active acquisition has no effect on the timing, the count or the active flag.
- R9: With the external source, a rising `ext_clk` first sampled at edge A produces a strobe in the cycle after edge A+2.
- R10: With pulse output selected (`cfg_level`=0), `sample_out` is high for exactly the strobe cycles.
- R11: With level output selected (`cfg_level`=1), `sample_out` goes high with each strobe and stays high for P-1 cycles, where P is the clamped period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_period | input | W | Ticks between internal samples |
| cfg_delay | input | W | Ticks from start to first internal sample |
| cfg_count | input | W | Samples in a finite acquisition |
| cfg_finite | input | 1 | 1 = finite, 0 = continuous |
| cfg_ext_sel | input | 1 | 1 = external sample clock |
| cfg_level | input | 1 | 1 = level output, 0 = pulse output |
| start_trig | input | 1 | Starts an acquisition when idle |
| pause_trig | input | 1 | Masks sample events while high |
| sw_stop | input | 1 | Ends the active acquisition |
| ext_clk | input | 1 | Asynchronous external sample clock |
| sample_strobe | output | 1 | One-tick strobe per accepted sample |
| sample_out | output | 1 | Per-sample output, pulse or level |
| acq_active | output | 1 | Acquisition in progress |
| acq_done | output | 1 | One-tick end-of-acquisition flag |

## Verification
The hardest case to reach from the ports is a pause that lands exactly on the edge of a sample event. A pause one tick early or late masks nothing, so the test gives no information unless the timing is exact. The bench runs its own model of the event schedule in step with the design. It raises `pause_trig` only for the edge that its model says carries a chosen event, picked by a bit mask over event indices. With this, masked and counted samples can be interleaved at will in both internal and external modes. The external case also needs the synchronizer latency counted exactly, so the bench drives `ext_clk` on a fixed pattern and its model places each event two edges after the first edge that samples the rise.

// File: rtl/acq_sample_timer.sv
module acq_sample_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_period,
  input  logic [W-1:0] cfg_delay,
  input  logic [W-1:0] cfg_count,
  input  logic         cfg_finite,
  input  logic         cfg_ext_sel,
  input  logic         cfg_level,
  input  logic         start_trig,
  input  logic         pause_trig,
  input  logic         sw_stop,
  input  logic         ext_clk,
  output logic         sample_strobe,
  output logic         sample_out,
  output logic         acq_active,
  output logic         acq_done
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] per_r, dly_r, cnt_r;
  logic         fin_r, ext_r, lvl_r;
  logic [W-1:0] per_c, dly_c, cnt_c;
  logic [2:0]   xs;
  logic         active_q, strobe_q, done_q;
  logic [W-1:0] tick, rem, hold;
  logic         ext_edge, event_now, take, final_take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_r <= TWO;
      dly_r <= TWO;
      cnt_r <= ONE;
      fin_r <= 1'b0;
      ext_r <= 1'b0;
      lvl_r <= 1'b0;
    end else if (cfg_we) begin
      per_r <= cfg_period;
      dly_r <= cfg_delay;
      cnt_r <= cfg_count;
      fin_r <= cfg_finite;
      ext_r <= cfg_ext_sel;
      lvl_r <= cfg_level;
    end

  assign per_c = (per_r < TWO) ? TWO : per_r;
  assign dly_c = (dly_r == '0) ? ONE : dly_r;
  assign cnt_c = (cnt_r == '0) ? ONE : cnt_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) xs <= '0;
    else        xs <= {xs[1:0], ext_clk};

  assign ext_edge   = xs[1] & ~xs[2];
  assign event_now  = active_q & (ext_r ? ext_edge : (tick == ONE));
  assign take       = event_now & ~pause_trig & ~sw_stop;
  assign final_take = take & fin_r & (rem == ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active_q <= 1'b0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
      tick     <= '0;
      rem      <= '0;
      hold     <= '0;
    end else begin
      strobe_q <= take;
      done_q   <= 1'b0;
      if (take)            hold <= per_c - ONE;
      else if (hold != '0) hold <= hold - ONE;
      if (!active_q) begin
        if (start_trig) begin
          active_q <= 1'b1;
          tick     <= dly_c;
          rem      <= cnt_c;
        end
      end else if (sw_stop) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        tick <= (tick == ONE) ? per_c : tick - ONE;
        if (take && fin_r) rem <= rem - ONE;
        if (final_take) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end

  assign sample_strobe = strobe_q;
  assign acq_active    = active_q;
  assign acq_done      = done_q;
  assign sample_out    = lvl_r ? (hold != '0) : strobe_q;

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(acq_active));
  // R4
  pause_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pause_trig) |-> !sample_strobe);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> !acq_done);
  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> (!acq_active && $past(acq_active)));
  // R8
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_active) |-> $past(start_trig));
  // R11
  level_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_r && sample_strobe) |-> sample_out);
endmodule

// File: tb/tb_acq_sample_timer.sv
module tb_acq_sample_timer;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_finite = 0, cfg_ext_sel = 0, cfg_level = 0;
  logic [W-1:0] cfg_period = '0, cfg_delay = '0, cfg_count = '0;
  logic start_trig = 0, pause_trig = 0, sw_stop = 0, ext_clk = 0;
  logic sample_strobe, sample_out, acq_active, acq_done;
  int n_chk = 0, n_bad = 0, cyc = 0;

  acq_sample_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_period(cfg_period),
    .cfg_delay(cfg_delay), .cfg_count(cfg_count), .cfg_finite(cfg_finite),
    .cfg_ext_sel(cfg_ext_sel), .cfg_level(cfg_level), .start_trig(start_trig),
    .pause_trig(pause_trig), .sw_stop(sw_stop), .ext_clk(ext_clk),
    .sample_strobe(sample_strobe), .sample_out(sample_out),
    .acq_active(acq_active), .acq_done(acq_done));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at t=%0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic run(int d, int p, int n, bit fin, bit lvl, bit ext,
                     logic [31:0] pmask, int stop_at, int restart_at, bit wcfg);
    int dc, pc, nc, nxt, step, rem, hold, m;
    bit alive, ev, ps, st, e_str, e_done;
    dc = (d == 0) ? 1 : d;
    pc = (p < 2) ? 2 : p;
    nc = (n == 0) ? 1 : n;
    @(negedge clk);
    if (wcfg) begin
      cfg_we = 1; cfg_period = W'(p); cfg_delay = W'(d); cfg_count = W'(n);
      cfg_finite = fin; cfg_ext_sel = ext; cfg_level = lvl;
      @(negedge clk);
      cfg_we = 0;
    end
    for (int i = 0; i < 10; i++) begin
      ext_clk = ext && (i < 6) && ((i % 4) < 2);
      @(negedge clk);
      chk("R5", "idle strobe", sample_strobe, 1'b0);
      chk("R5", "idle active", acq_active, 1'b0);
    end
    ext_clk = 0;
    start_trig = 1;
    @(negedge clk);
    start_trig = 0;
    chk("R2", "active after start", acq_active, 1'b1);
    alive = 1; rem = nc; hold = 0; m = 0;
    nxt = ext ? 4 : dc;
    step = ext ? 6 : pc;
    for (int k = 1; k <= 40; k++) begin
      ev = alive && (k == nxt);
      st = alive && (k == stop_at);
      ps = ev && pmask[m];
      pause_trig = ps;
      sw_stop = (k == stop_at);
      start_trig = (k == restart_at);
      ext_clk = ext && (k >= 2) && (((k - 2) % 6) < 3);
      e_str = 0; e_done = 0;
      if (alive) begin
        if (st) begin
          alive = 0; e_done = 1;
        end else if (ev) begin
          nxt += step; m++;
          if (!ps) begin
            e_str = 1;
            if (fin) begin
              rem--;
              if (rem == 0) begin alive = 0; e_done = 1; end
            end
          end
        end
      end
      if (e_str) hold = pc - 1; else if (hold > 0) hold--;
      @(negedge clk);
      chk("R2 R3 R4 R9", "strobe", sample_strobe, e_str);
      chk(lvl ? "R11" : "R10", "sample_out", sample_out, lvl ? (hold > 0) : e_str);
      chk("R6 R7 R8", "active", acq_active, alive);
      chk("R6 R7", "done", acq_done, e_done);
    end
    pause_trig = 0; sw_stop = 0; start_trig = 0; ext_clk = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset strobe", sample_strobe, 1'b0);
    chk("R1", "reset out", sample_out, 1'b0);
    chk("R1", "reset active", acq_active, 1'b0);
    chk("R1", "reset done", acq_done, 1'b0);
    rst_n = 1;
    // R1 R2: reset defaults (delay 2, period 2, continuous, pulse), ended by stop
    run(2, 2, 1, 0, 0, 0, 32'h0, 9, 0, 0);
    // R7: sw_stop while idle leaves the engine idle
    sw_stop = 1;
    repeat (3) @(negedge clk);
    chk("R7", "idle stop ignored", acq_active, 1'b0);
    chk("R7", "idle stop no done", acq_done, 1'b0);
    sw_stop = 0;
    // R2 R3 R6 R10 R11: finite sweep over delay, period, count and output style
    for (int d = 0; d <= 4; d++)
      for (int p = 0; p <= 5; p++)
        for (int n = 0; n <= 4; n++)
          for (int l = 0; l <= 1; l++)
            run(d, p, n, 1, l[0], 0, 32'h0, 0, 0, 1);
    // R3 R7: continuous runs ended by software stop
    for (int p = 2; p <= 5; p++) run(1, p, 0, 0, p[0], 0, 32'h0, 17, 0, 1);
    // R4: pause masks chosen events in finite and continuous modes
    for (int msk = 1; msk < 16; msk++) begin
      run(2, 3, 3, 1, 0, 0, 32'(msk), 0, 0, 1);
      run(3, 4, 0, 0, 1, 0, 32'(msk), 20, 0, 1);
    end
    // R7: stop in the middle of a finite acquisition
    run(2, 5, 4, 1, 0, 0, 32'h0, 8, 0, 1);
    // R8: restart attempts during acquisition
    for (int r = 1; r <= 6; r++) run(3, 3, 3, 1, 0, 0, 32'h0, 0, r, 1);
    // R9 R5 R4: external source, with idle toggles and masked edges
    run(0, 2, 3, 1, 0, 1, 32'h0, 0, 0, 1);
    run(0, 4, 3, 1, 1, 1, 32'h2, 0, 0, 1);
    run(0, 3, 0, 0, 0, 1, 32'h5, 25, 3, 1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule